// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is an 8-bit down-counter that paces itself on one of four externally generated rate strobes (nominally 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz). A shared prescaler outside the block produces these strobes, each one system clock wide. Software sets up the block through a simple register bus. It chooses the rate, loads a period value and enables counting. When the period runs out, the block sets a sticky timer flag and reloads itself, so it repeats indefinitely.

An active-low interrupt pin reports each expiry in one of two ways. In level mode the pin stays low for as long as the flag is set and the interrupt is enabled. In pulse mode the pin drops at the expiry and rises again at the next strobe of the selected rate. Software clears the flag by writing 0 to it; writing 1 to it changes nothing. The block moves no streamed data. Its bus is a plain single-cycle write port plus a combinational read port, so it needs no valid/ready handshake and never applies back-pressure.

Top module: `cdtimer_top`

## Requirements
- R1: After reset, every register reads 0, the counter is 0 and the interrupt pin is high.
- R2: The timer control register at address 0xE holds the enable in bit 7 and the rate select in bits 1:0. All other bits read 0.
- R3: A rate select of 0, 1, 2 or 3 makes the counter step only on strobe 0 (4096 Hz), 1 (64 Hz), 2 (1 Hz) or 3 (1/60 Hz). Strobes of unselected rates have no effect.
- R4: The period register sits at address 0xF and reads back what was written. Writing it loads the counter at once, and that load takes priority over counting in the same cycle.
- R5: While enabled with a period N > 0, a selected strobe that finds the counter at 1 or below is an expiry. An expiry sets the flag and reloads N, so expiries recur every N selected strobes.
- R6: With a period of 0 the timer stays idle and never sets the flag.
- R7: In control register 2 at address 0x1, bit 2 is the flag. Writing 0 to bit 2 clears it, writing 1 leaves it unchanged, and an expiry in the same cycle as a clear wins.
- R8: Bit 0 of control register 2 enables the interrupt, bit 4 selects pulse (1) or level (0) mode, and the other bits read 0. With the enable at 0 the pin stays high.
- R9: In level mode the pin is low exactly while both the flag and the interrupt enable are set.
- R10: In pulse mode the pin goes low from the cycle after an expiry until the cycle after the next selected strobe.
- R11: With the enable bit at 0, strobes do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_tick_i | input | 4 | One-cycle rate strobes, index = rate select code |
| bus_wr_i | input | 1 | Register write strobe |
| bus_waddr_i | input | 4 | Write address |
| bus_wdata_i | input | 8 | Write data |
| bus_raddr_i | input | 4 | Read address |
| bus_rdata_o | output | 8 | Read data (combinational) |
| tmr_int_no | output | 1 | Active-low timer interrupt |

## Verification
The assertions assume that each strobe is a single-cycle pulse synchronous to the clock, and that the bus performs at most one write per cycle to a stable address. They accept strobes on several rates in the same cycle, and they accept register writes that coincide with an expiry. The stimulus drives the strobes and the bus only on the falling clock edge. It mixes directed phases with a long random phase. That random phase asserts several strobes together, writes the period while counting and clears the flag near expiries, which keeps every input inside those assumptions while still reaching the coincident cases.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
  localparam int ADDR_CTRL2 = 1;
  localparam int ADDR_TCTL  = 14;
  localparam int ADDR_TCNT  = 15;
  localparam int C2_IE      = 0;
  localparam int C2_FLAG    = 2;
  localparam int C2_MODE    = 4;
  localparam int TC_EN      = 7;
endpackage

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
  import cdtimer_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int SELW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            expire_i,
  output logic            en_o,
  output logic [SELW-1:0] sel_o,
  output logic [DW-1:0]   reload_o,
  output logic            load_o,
  output logic            ie_o,
  output logic            mode_o,
  output logic            flag_o
);
  logic wr_c2, wr_tc;
  logic ie_q, mode_q, flag_q, en_q;
  logic [SELW-1:0] sel_q;
  logic [DW-1:0] rel_q;

  assign wr_c2  = wr_i && (waddr_i == AW'(ADDR_CTRL2));
  assign wr_tc  = wr_i && (waddr_i == AW'(ADDR_TCTL));
  assign load_o = wr_i && (waddr_i == AW'(ADDR_TCNT));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ie_q <= 1'b0; mode_q <= 1'b0; flag_q <= 1'b0;
      en_q <= 1'b0; sel_q <= '0; rel_q <= '0;
    end else begin
      if (wr_c2) begin
        ie_q   <= wdata_i[C2_IE];
        mode_q <= wdata_i[C2_MODE];
      end
      if (expire_i)                        flag_q <= 1'b1;
      else if (wr_c2 && !wdata_i[C2_FLAG]) flag_q <= 1'b0;
      if (wr_tc) begin
        en_q  <= wdata_i[TC_EN];
        sel_q <= wdata_i[SELW-1:0];
      end
      if (load_o) rel_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (raddr_i == AW'(ADDR_CTRL2)) begin
      rdata_o[C2_IE]   = ie_q;
      rdata_o[C2_FLAG] = flag_q;
      rdata_o[C2_MODE] = mode_q;
    end else if (raddr_i == AW'(ADDR_TCTL)) begin
      rdata_o[TC_EN]      = en_q;
      rdata_o[SELW-1:0]   = sel_q;
    end else if (raddr_i == AW'(ADDR_TCNT)) begin
      rdata_o = rel_q;
    end
  end

  assign en_o = en_q;  assign sel_o = sel_q;  assign reload_o = rel_q;
  assign ie_o = ie_q;  assign mode_o = mode_q; assign flag_o = flag_q;

  // R7
  flag_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(expire_i));
  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c2 && !wdata_i[C2_FLAG] && !expire_i) |=> !flag_q);
endmodule

// File: rtl/cdtimer_counter.sv
module cdtimer_counter #(
  parameter int CW   = 8,
  parameter int NSRC = 4,
  parameter int SELW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] tick_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            en_i,
  input  logic [CW-1:0]   reload_i,
  input  logic            load_i,
  input  logic [CW-1:0]   load_val_i,
  output logic            tick_sel_o,
  output logic            expire_o
);
  logic [CW-1:0] cnt_q;

  assign tick_sel_o = tick_i[sel_i];
  assign expire_o   = en_i && (reload_i != '0) && tick_sel_o && (cnt_q <= CW'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (load_i)                               cnt_q <= load_val_i;
    else if (expire_o)                             cnt_q <= reload_i;
    else if (en_i && tick_sel_o && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  // R5
  reload_on_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !load_i) |=> cnt_q == $past(reload_i));
  // R11
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
  // R4
  load_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/cdtimer_irq.sv
module cdtimer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic tick_sel_i,
  input  logic ie_i,
  input  logic mode_i,
  input  logic flag_i,
  output logic int_no
);
  logic pulse_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         pulse_q <= 1'b0;
    else if (expire_i)   pulse_q <= 1'b1;
    else if (tick_sel_i) pulse_q <= 1'b0;
  end

  assign int_no = !(ie_i && (mode_i ? pulse_q : flag_i));

  // R10
  low_after_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> int_no == !ie_i);
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top #(
  parameter int NSRC = 4,
  parameter int AW   = 4,
  parameter int DW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_tick_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_waddr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  input  logic [AW-1:0]   bus_raddr_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            tmr_int_no
);
  localparam int SELW = $clog2(NSRC);
  localparam int CW   = DW;

  logic en, load, ie, mode, flag, expire, tick_sel;
  logic [SELW-1:0] sel;
  logic [CW-1:0] reload;

  cdtimer_regs #(.AW(AW), .DW(DW), .SELW(SELW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .waddr_i(bus_waddr_i),
    .wdata_i(bus_wdata_i), .raddr_i(bus_raddr_i), .rdata_o(bus_rdata_o),
    .expire_i(expire), .en_o(en), .sel_o(sel), .reload_o(reload),
    .load_o(load), .ie_o(ie), .mode_o(mode), .flag_o(flag));

  cdtimer_counter #(.CW(CW), .NSRC(NSRC), .SELW(SELW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(src_tick_i), .sel_i(sel),
    .en_i(en), .reload_i(reload), .load_i(load), .load_val_i(bus_wdata_i),
    .tick_sel_o(tick_sel), .expire_o(expire));

  cdtimer_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .tick_sel_i(tick_sel),
    .ie_i(ie), .mode_i(mode), .flag_i(flag), .int_no(tmr_int_no));
endmodule

// File: tb/tb_cdtimer_top.sv
module tb_cdtimer_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] tick = '0;
  logic wr = 1'b0;
  logic [3:0] waddr = '0, raddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic int_n;

  always #2.5 clk = ~clk;

  cdtimer_top dut (.clk_i(clk), .rst_ni(rst_n), .src_tick_i(tick), .bus_wr_i(wr),
    .bus_waddr_i(waddr), .bus_wdata_i(wdata), .bus_raddr_i(raddr),
    .bus_rdata_o(rdata), .tmr_int_no(int_n));

  int errors = 0, checks = 0, cycles = 0, rr = 0;
  string ph = "R1";
  int m_cnt = 0, m_rel = 0, m_sel = 0;
  bit m_ie = 0, m_mode = 0, m_flag = 0, m_en = 0, m_pulse = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", ph, what, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on each rising edge, compared 1 ns later.
  always @(posedge clk) begin
    bit tk, ex;
    int exp_rd, exp_int;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_sel = 0;
      m_ie = 0; m_mode = 0; m_flag = 0; m_en = 0; m_pulse = 0;
    end else begin
      tk = tick[m_sel];
      ex = m_en && m_rel != 0 && tk && m_cnt <= 1;
      if (ex) m_pulse = 1; else if (tk) m_pulse = 0;
      if (ex) m_flag = 1; else if (wr && waddr == 1 && !wdata[2]) m_flag = 0;
      if (wr && waddr == 15) m_cnt = wdata;
      else if (ex) m_cnt = m_rel;
      else if (m_en && tk && m_cnt != 0) m_cnt = m_cnt - 1;
      if (wr && waddr == 1) begin m_ie = wdata[0]; m_mode = wdata[4]; end
      if (wr && waddr == 14) begin m_en = wdata[7]; m_sel = wdata[1:0]; end
      if (wr && waddr == 15) m_rel = wdata;
    end
    #1;
    case (raddr)
      4'h1:    exp_rd = (int'(m_mode) << 4) | (int'(m_flag) << 2) | int'(m_ie);
      4'hE:    exp_rd = (int'(m_en) << 7) | m_sel;
      4'hF:    exp_rd = m_rel;
      default: exp_rd = 0;
    endcase
    exp_int = (m_ie && (m_mode ? m_pulse : m_flag)) ? 0 : 1;
    check(int_n == exp_int[0], "int_n (R9 R10 R8)", int'(int_n), exp_int);
    check(int'(rdata) == exp_rd,
          (raddr == 1) ? "ctrl2 R7" : (raddr == 14) ? "tctl R2" : "period R4",
          int'(rdata), exp_rd);
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input logic [3:0] tk, input logic w = 0,
                     input logic [3:0] a = 0, input logic [7:0] d = 0);
    @(negedge clk);
    tick = tk; wr = w; waddr = a; wdata = d;
    case (rr % 3) 0: raddr = 4'h1; 1: raddr = 4'hE; default: raddr = 4'hF; endcase
    rr++;
  endtask

  task automatic idle(input int n, input logic [3:0] tk = 0);
    for (int i = 0; i < n; i++) cyc(tk);
  endtask

  initial begin
    ph = "R1"; idle(6); rst_n = 1'b1;
    @(negedge clk);
    ph = "R1";  idle(3);
    ph = "R2";  cyc(0, 1, 4'hE, 8'hFF); idle(3); cyc(0, 1, 4'hE, 8'h00); idle(3);
    ph = "R4";  cyc(0, 1, 4'hF, 8'd3); idle(3);
    ph = "R11"; idle(10, 4'hF);
    ph = "R9";  cyc(0, 1, 4'h1, 8'h01); cyc(0, 1, 4'hE, 8'h80);
    for (int i = 0; i < 12; i++) begin cyc(4'h1); cyc(0); end
    ph = "R7";  cyc(0, 1, 4'h1, 8'h05); idle(3); cyc(0, 1, 4'h1, 8'h01); idle(3);
    ph = "R3";  cyc(0, 1, 4'hE, 8'h82); idle(12, 4'hB);
    for (int i = 0; i < 6; i++) begin cyc(4'h4); cyc(0); end
    ph = "R10"; cyc(0, 1, 4'h1, 8'h11);
    for (int i = 0; i < 10; i++) begin cyc(4'h4); idle(4); end
    ph = "R6";  cyc(0, 1, 4'hF, 8'h00); cyc(0, 1, 4'h1, 8'h01); idle(20, 4'hF);
    ph = "R8";  cyc(0, 1, 4'hF, 8'h01); idle(3, 4'h4); cyc(0, 1, 4'h1, 8'h00); idle(4, 4'h4);
    ph = "R5";
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] t;
      int r;
      t = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
      r = $urandom_range(0, 99);
      if (r < 3)      cyc(t, 1, 4'hF, 8'($urandom_range(0, 5)));
      else if (r < 6) cyc(t, 1, 4'h1, 8'($urandom));
      else if (r < 8) cyc(t, 1, 4'hE, 8'($urandom) | 8'h80);
      else if (r < 9) cyc(t, 1, 4'hE, 8'($urandom));
      else            cyc(t);
    end
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule